// File: doc/BRIEF.md
# Powered-Rail ADC Measurement Sequencer

This controller takes a single reading from an external analog-to-digital converter that sits behind an I2C slave. It only works while the converter's supply rail is on. A measurement starts in one of two ways: the mode code changes to one of the meter codes, or the push-button is pressed while a meter code is selected.

Each measurement runs in a fixed order:

1. Raise the rail enable.
2. Wait for a programmable settle time.
3. Drive a byte-level I2C master through three transactions. The first writes the channel-select and start-conversion byte. The second sets the device's register pointer to the result register. The third reads two result bytes.
4. Store the 16-bit value in a display register and drop the rail.

The stored value stays on the output after the rail is off.

The I2C master that does the bit-level signalling sits outside this block. The controller hands it one command at a time: an operation, a data byte and a stop flag. It then waits for that command's response before it issues the next one. A NACK on any command ends the measurement at once. The rail goes off, an error flag is raised and the stored value is not touched.

Top module: `meas_seq_top`

## Requirements
- R1: A measurement starts in one of two cases. The first is a clock in which `mode_sel` holds a meter code that differs from its value in the previous clock; after reset the previous value counts as 4'b1111. The second is a clock in which `button` goes from 0 to 1 while `mode_sel` holds a meter code. Triggers that arrive during a measurement are ignored.
- R2: `rail_en` goes high in the clock after the trigger. It is high for exactly `settle_len`+1 clocks before `cmd_valid` is first seen high. It stays high only while `busy` is high.
- R3: A complete measurement issues exactly eight commands, with these (`cmd_op`, `cmd_data`, `cmd_stop`) values:
  1. (0, 2*DEV_ADDR, 0)
  2. (1, MUX_REG, 0)
  3. (1, 8'h80|channel, 1)
  4. (0, 2*DEV_ADDR, 0)
  5. (1, RES_REG, 1)
  6. (0, 2*DEV_ADDR+1, 0)
  7. (2, 0, 0)
  8. (3, 0, 1)

  The `cmd_op` values mean: 0 = start condition then send the byte, 1 = send the byte, 2 = read a byte and acknowledge it, 3 = read the last byte and do not acknowledge it.
- R4: The channel is taken from the mode code that started the measurement: 4'b1100 and 4'b1000 give channel 1, 4'b1001 gives 2, 4'b1010 gives 5 and 4'b1011 gives 6. Only these five codes are meter codes.
- R5: Each `cmd_valid` pulse lasts one clock. The next pulse comes only after `rsp_valid` has answered the previous one.
- R6: After the eighth response, `result` becomes {data of the seventh response, data of the eighth response}. `result` holds that value until the next measurement completes, including after `rail_en` falls.
- R7: `disp_valid` is high only while `mode_sel` holds a meter code and at least one measurement has completed since reset. Standby (4'b1111) and every other non-meter code start no measurement and keep `disp_valid` low.
- R8: A response with `rsp_nack` high ends the measurement. `rail_en` and `busy` are low in the next clock, `err` is set and `result` is unchanged. `err` is cleared when the next measurement starts.
- R9: A press of `button` while a non-meter code is selected starts no measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 4 | Mode switch code |
| button | input | 1 | Push-button, synchronous and debounced |
| settle_len | input | SETTLE_W | Settle clocks after the rail is enabled |
| rail_en | output | 1 | Enable for the measurement device's supply rail |
| busy | output | 1 | A measurement is in progress |
| cmd_valid | output | 1 | One-clock command strobe to the I2C master |
| cmd_op | output | 2 | Command operation: 0 start+send, 1 send, 2 read with ACK, 3 read with NACK |
| cmd_data | output | 8 | Byte to send |
| cmd_stop | output | 1 | Issue a stop condition after this command |
| rsp_valid | input | 1 | Response strobe from the I2C master |
| rsp_nack | input | 1 | The slave did not acknowledge |
| rsp_data | input | 8 | Byte received by a read command |
| result | output | 16 | Latched measurement |
| disp_valid | output | 1 | The latched measurement may be displayed |
| err | output | 1 | The last measurement was aborted by a NACK |

## Verification
The assertions assume that the I2C master raises `rsp_valid` only while a command is outstanding, and for exactly one clock per command. They also assume that `button` is already synchronous. The bench's responder model answers each command exactly once, a fixed number of clocks after seeing it. `button` and `mode_sel` change only at falling edges and only while the controller is idle. A NACK is injected at a chosen command index, never after the sequence has ended.

// File: rtl/meas_seq_pkg.sv
package meas_seq_pkg;

    typedef enum logic [1:0] {
        OP_START     = 2'd0,
        OP_WRITE     = 2'd1,
        OP_READ      = 2'd2,
        OP_READ_LAST = 2'd3
    } i2c_op_e;

    typedef struct packed {
        i2c_op_e    op;
        logic [7:0] data;
        logic       stop;
    } i2c_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_ISSUE,
        ST_WAIT
    } seq_state_e;

    typedef struct packed {
        logic       meter;
        logic [3:0] chan;
    } mode_info_t;

    localparam int unsigned NUM_STEPS = 8;
    localparam int unsigned STEP_W    = $clog2(NUM_STEPS);
    localparam logic [STEP_W-1:0] HI_STEP = STEP_W'(NUM_STEPS - 2);
    localparam logic [STEP_W-1:0] LO_STEP = STEP_W'(NUM_STEPS - 1);

    function automatic mode_info_t decode_mode(input logic [3:0] code);
        mode_info_t m;
        m = '{meter: 1'b1, chan: 4'd0};
        case (code)
            4'b1100, 4'b1000: m.chan = 4'd1;
            4'b1001:          m.chan = 4'd2;
            4'b1010:          m.chan = 4'd5;
            4'b1011:          m.chan = 4'd6;
            default:          m.meter = 1'b0;
        endcase
        return m;
    endfunction

    function automatic i2c_cmd_t step_cmd(
        input logic [STEP_W-1:0] step,
        input logic [3:0]        chan,
        input logic [6:0]        dev_addr,
        input logic [7:0]        mux_reg,
        input logic [7:0]        res_reg
    );
        i2c_cmd_t c;
        c = '{op: OP_WRITE, data: 8'h00, stop: 1'b0};
        case (step)
            3'd0: begin c.op = OP_START; c.data = {dev_addr, 1'b0}; end
            3'd1: c.data = mux_reg;
            3'd2: begin c.data = {4'b1000, chan}; c.stop = 1'b1; end
            3'd3: begin c.op = OP_START; c.data = {dev_addr, 1'b0}; end
            3'd4: begin c.data = res_reg; c.stop = 1'b1; end
            3'd5: begin c.op = OP_START; c.data = {dev_addr, 1'b1}; end
            3'd6: c.op = OP_READ;
            default: begin c.op = OP_READ_LAST; c.stop = 1'b1; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/meas_trigger.sv
module meas_trigger
    import meas_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] mode_sel,
    input  logic       button,
    output mode_info_t info,
    output logic       trigger
);
    logic [3:0] prev_mode;
    logic       btn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_mode <= 4'hF;
            btn_q     <= 1'b0;
        end else begin
            prev_mode <= mode_sel;
            btn_q     <= button;
        end
    end

    always_comb begin
        info    = decode_mode(mode_sel);
        trigger = info.meter && ((mode_sel != prev_mode) || (button && !btn_q));
    end

endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int unsigned SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [SETTLE_W-1:0] len,
    input  logic                run,
    output logic                done
);
    logic [SETTLE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= len;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!load && !run) |=> $stable(cnt));

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import meas_seq_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h08,
    parameter logic [7:0] MUX_REG  = 8'h07,
    parameter logic [7:0] RES_REG  = 8'h0A
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trigger,
    input  logic [3:0] trig_chan,
    input  logic       settle_done,
    input  logic       rsp_valid,
    input  logic       rsp_nack,
    output logic       settle_load,
    output logic       settle_run,
    output logic       busy,
    output logic       cmd_valid,
    output i2c_cmd_t   cmd,
    output logic       cap_hi,
    output logic       cap_lo,
    output logic       err
);
    seq_state_e        state;
    logic [STEP_W-1:0] step;
    logic [3:0]        chan_q;
    logic              rsp_ok;

    assign rsp_ok = (state == ST_WAIT) && rsp_valid && !rsp_nack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            step   <= '0;
            chan_q <= 4'd0;
            err    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (trigger) begin
                    state  <= ST_SETTLE;
                    step   <= '0;
                    chan_q <= trig_chan;
                    err    <= 1'b0;
                end
                ST_SETTLE: if (settle_done) state <= ST_ISSUE;
                ST_ISSUE:  state <= ST_WAIT;
                default: if (rsp_valid) begin
                    if (rsp_nack) begin
                        state <= ST_IDLE;
                        err   <= 1'b1;
                    end else if (step == LO_STEP) begin
                        state <= ST_IDLE;
                    end else begin
                        step  <= step + 1'b1;
                        state <= ST_ISSUE;
                    end
                end
            endcase
        end
    end

    always_comb begin
        settle_load = (state == ST_IDLE) && trigger;
        settle_run  = (state == ST_SETTLE);
        busy        = (state != ST_IDLE);
        cmd_valid   = (state == ST_ISSUE);
        cmd         = step_cmd(step, chan_q, DEV_ADDR, MUX_REG, RES_REG);
        cap_hi      = rsp_ok && (step == HI_STEP);
        cap_lo      = rsp_ok && (step == LO_STEP);
    end

    assert_single_outstanding_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);
    assert_nack_abort_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && rsp_valid && rsp_nack) |=> (!busy && err));
    assert_first_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && $past(state) == ST_SETTLE) |-> (cmd.op == OP_START && step == '0));

endmodule

// File: rtl/result_latch.sv
module result_latch #(
    parameter int unsigned RES_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_hi,
    input  logic             cap_lo,
    input  logic [7:0]       data,
    output logic [RES_W-1:0] result,
    output logic             have_result
);
    localparam int unsigned HALF = RES_W / 2;
    logic [HALF-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q        <= '0;
            result      <= '0;
            have_result <= 1'b0;
        end else begin
            if (cap_hi) hi_q <= HALF'(data);
            if (cap_lo) begin
                result      <= {hi_q, HALF'(data)};
                have_result <= 1'b1;
            end
        end
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !cap_lo |=> $stable(result));
    assert_exclusive_caps_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cap_hi, cap_lo}));

endmodule

// File: rtl/meas_seq_top.sv
module meas_seq_top
    import meas_seq_pkg::*;
#(
    parameter int unsigned SETTLE_W = 8,
    parameter logic [6:0]  DEV_ADDR = 7'h08,
    parameter logic [7:0]  MUX_REG  = 8'h07,
    parameter logic [7:0]  RES_REG  = 8'h0A
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [3:0]          mode_sel,
    input  logic                button,
    input  logic [SETTLE_W-1:0] settle_len,
    output logic                rail_en,
    output logic                busy,
    output logic                cmd_valid,
    output logic [1:0]          cmd_op,
    output logic [7:0]          cmd_data,
    output logic                cmd_stop,
    input  logic                rsp_valid,
    input  logic                rsp_nack,
    input  logic [7:0]          rsp_data,
    output logic [15:0]         result,
    output logic                disp_valid,
    output logic                err
);
    mode_info_t info;
    i2c_cmd_t   cmd;
    logic trigger, settle_load, settle_run, settle_done;
    logic cap_hi, cap_lo, have_result;

    meas_trigger u_trig (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .button(button),
        .info(info), .trigger(trigger)
    );

    settle_timer #(.SETTLE_W(SETTLE_W)) u_settle (
        .clk(clk), .rst(rst), .load(settle_load), .len(settle_len),
        .run(settle_run), .done(settle_done)
    );

    seq_fsm #(.DEV_ADDR(DEV_ADDR), .MUX_REG(MUX_REG), .RES_REG(RES_REG)) u_fsm (
        .clk(clk), .rst(rst), .trigger(trigger), .trig_chan(info.chan),
        .settle_done(settle_done), .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
        .settle_load(settle_load), .settle_run(settle_run), .busy(busy),
        .cmd_valid(cmd_valid), .cmd(cmd), .cap_hi(cap_hi), .cap_lo(cap_lo),
        .err(err)
    );

    result_latch #(.RES_W(16)) u_latch (
        .clk(clk), .rst(rst), .cap_hi(cap_hi), .cap_lo(cap_lo),
        .data(rsp_data), .result(result), .have_result(have_result)
    );

    always_comb begin
        rail_en    = busy;
        cmd_op     = cmd.op;
        cmd_data   = cmd.data;
        cmd_stop   = cmd.stop;
        disp_valid = have_result && info.meter;
    end

    assert_cmd_with_rail_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> rail_en);
    assert_start_meter_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(rail_en) |-> decode_mode($past(mode_sel)).meter);
    assert_idle_result_R6: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(result));
    assert_no_display_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 4'hF) |-> !disp_valid);

endmodule

// File: tb/meas_seq_top_test.sv
module meas_seq_top_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] mode_sel = 4'hF;
    logic button = 1'b0;
    logic [7:0] settle_len = 8'd0;
    logic rail_en, busy, cmd_valid, cmd_stop, disp_valid, err;
    logic [1:0] cmd_op;
    logic [7:0] cmd_data;
    logic rsp_valid = 1'b0, rsp_nack = 1'b0;
    logic [7:0] rsp_data = 8'h00;
    logic [15:0] result;

    always #2 clk = ~clk;

    meas_seq_top uut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .button(button),
        .settle_len(settle_len), .rail_en(rail_en), .busy(busy),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .cmd_stop(cmd_stop), .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
        .rsp_data(rsp_data), .result(result), .disp_valid(disp_valid),
        .err(err)
    );

    int checks = 0, errors = 0;
    int log_n = 0, pre_cmd = 0, rail_rises = 0, nack_at = -1;
    logic rail_d = 1'b0;
    logic [1:0] log_op [0:15];
    logic [7:0] log_data [0:15];
    logic log_stop [0:15];
    logic [7:0] hi_val = 8'h00, lo_val = 8'h00;

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // I2C master responder model
    initial begin
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            rsp_nack  = 1'b0;
            if (rail_en && !rail_d) rail_rises++;
            rail_d = rail_en;
            if (rail_en && log_n == 0 && !cmd_valid) pre_cmd++;
            if (cmd_valid) begin
                if (log_n < 16) begin
                    log_op[log_n] = cmd_op;
                    log_data[log_n] = cmd_data;
                    log_stop[log_n] = cmd_stop;
                end
                log_n++;
                @(negedge clk);
                rail_d = rail_en;
                @(negedge clk);
                rail_d = rail_en;
                rsp_valid = 1'b1;
                rsp_nack = (nack_at == log_n - 1);
                rsp_data = (cmd_op == 2'd2) ? hi_val : (cmd_op == 2'd3) ? lo_val : 8'h00;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic is_meter(input logic [3:0] c);
        return (c == 4'hC) || (c == 4'h8) || (c == 4'h9) || (c == 4'hA) || (c == 4'hB);
    endfunction

    function automatic logic [3:0] chan_of(input logic [3:0] c);
        case (c)
            4'hC, 4'h8: return 4'd1;
            4'h9: return 4'd2;
            4'hA: return 4'd5;
            4'hB: return 4'd6;
            default: return 4'd0;
        endcase
    endfunction

    task automatic clear_log();
        log_n = 0;
        pre_cmd = 0;
        rail_rises = 0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!rail_en && t < 40) begin @(negedge clk); t++; end
        while (rail_en && t < 2000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_seq(input logic [3:0] ch, input int settle);
        logic [1:0] eop;
        logic [7:0] edat;
        logic estp;
        chk(log_n == 8, "R3", "command count", log_n, 8);
        chk(pre_cmd == settle + 1, "R2", "settle clocks", pre_cmd, settle + 1);
        for (int i = 0; i < 8 && i < log_n; i++) begin
            case (i)
                0, 3: begin eop = 2'd0; edat = 8'h10; estp = 1'b0; end
                1: begin eop = 2'd1; edat = 8'h07; estp = 1'b0; end
                2: begin eop = 2'd1; edat = 8'h80 | {4'h0, ch}; estp = 1'b1; end
                4: begin eop = 2'd1; edat = 8'h0A; estp = 1'b1; end
                5: begin eop = 2'd0; edat = 8'h11; estp = 1'b0; end
                6: begin eop = 2'd2; edat = 8'h00; estp = 1'b0; end
                default: begin eop = 2'd3; edat = 8'h00; estp = 1'b1; end
            endcase
            chk(log_op[i] == eop, "R3", "cmd op", int'(log_op[i]), int'(eop));
            chk(log_stop[i] == estp, "R3", "cmd stop", int'(log_stop[i]), int'(estp));
            if (i == 2)
                chk(log_data[i] == edat, "R4", "channel byte", int'(log_data[i]), int'(edat));
            else if (i < 6)
                chk(log_data[i] == edat, "R3", "cmd data", int'(log_data[i]), int'(edat));
        end
    endtask

    task automatic pulse_button();
        @(negedge clk); button = 1'b1;
        @(negedge clk); button = 1'b0;
    endtask

    initial begin
        logic [15:0] last;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!rail_en && !cmd_valid && !busy, "R2", "reset rail/cmd", int'(rail_en), 0);
        chk(result == 16'h0 && !disp_valid && !err, "R7", "reset outputs", int'(result), 0);
        last = 16'h0;

        // sweep over every mode code, each entered from standby
        for (int c = 0; c < 16; c++) begin
            mode_sel = 4'hF;
            repeat (4) @(negedge clk);
            clear_log();
            settle_len = 8'(c % 5);
            hi_val = 8'(c * 17 + 3);
            lo_val = 8'(255 - c * 9);
            mode_sel = 4'(c);
            if (is_meter(4'(c))) begin
                wait_done();
                check_seq(chan_of(4'(c)), c % 5);
                chk(result == {hi_val, lo_val}, "R6", "result", int'(result),
                    int'({hi_val, lo_val}));
                chk(disp_valid, "R7", "display in meter mode", int'(disp_valid), 1);
                chk(!rail_en && !err, "R2", "rail off after run", int'(rail_en), 0);
                chk(rail_rises == 1, "R1", "one run per selection", rail_rises, 1);
                last = {hi_val, lo_val};
                mode_sel = 4'hF;
                repeat (3) @(negedge clk);
                chk(result == last, "R6", "held in standby", int'(result), int'(last));
                chk(!disp_valid, "R7", "no display in standby", int'(disp_valid), 0);
            end else begin
                repeat (40) @(negedge clk);
                chk(log_n == 0 && rail_rises == 0, "R7", "no run for non-meter",
                    log_n, 0);
                chk(!disp_valid, "R7", "no display non-meter", int'(disp_valid), 0);
                chk(result == last, "R6", "result kept", int'(result), int'(last));
            end
        end

        // button in standby
        mode_sel = 4'hF;
        repeat (4) @(negedge clk);
        clear_log();
        pulse_button();
        repeat (40) @(negedge clk);
        chk(log_n == 0 && rail_rises == 0, "R9", "button ignored", log_n, 0);

        // button in meter mode
        mode_sel = 4'h9;
        settle_len = 8'd2;
        wait_done();
        last = result;
        clear_log();
        hi_val = 8'hA5; lo_val = 8'h3C;
        settle_len = 8'd7;
        pulse_button();
        wait_done();
        check_seq(4'd2, 7);
        chk(rail_rises == 1, "R1", "button starts run", rail_rises, 1);
        chk(result == 16'hA53C, "R6", "button result", int'(result), 16'hA53C);
        last = result;

        // NACK aborts at several command indices
        for (int k = 0; k < 8; k += 3) begin
            clear_log();
            nack_at = k;
            hi_val = 8'h11; lo_val = 8'h22;
            settle_len = 8'd1;
            pulse_button();
            wait_done();
            nack_at = -1;
            chk(err, "R8", "error flag", int'(err), 1);
            chk(log_n == k + 1, "R8", "commands before abort", log_n, k + 1);
            chk(result == last, "R8", "result unchanged", int'(result), int'(last));
            chk(!rail_en, "R8", "rail off", int'(rail_en), 0);
        end
        clear_log();
        hi_val = 8'h5A; lo_val = 8'hC3;
        pulse_button();
        repeat (3) @(negedge clk);
        chk(!err && busy, "R8", "error cleared on start", int'(err), 0);
        wait_done();
        chk(result == 16'h5AC3, "R6", "result after recovery", int'(result), 16'h5AC3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule